// File: doc/BRIEF.md
# Charge Pump Charging Timer

This block measures how long a charge pump needs to reach its target level. A charging-active input from the pump starts a timer from zero on each rising edge. The timer advances once per clock while charging continues. It stops when charging ends or when it reaches a programmable limit, whichever comes first. At that moment the running count is copied into a read-only elapsed-time output. That output then holds its value until the next charging episode finishes.

Only the limit case raises a sticky timeout flag. Software clears the flag with a write-1-to-clear pulse. An interrupt request follows the flag whenever the interrupt enable is set. In a register map, the limit and the elapsed value sit in bits 28:16 of their words. The flag sits in bit 2 of the status word, and the enable in bit 2 of the interrupt enable word. This block sees only the decoded fields.

Top module: `chgpump_timer`

## Requirements
- R1: After reset, `elapsed` is 0, `tmo_flag` is 0 and `tmo_irq` is 0.
- R2: If `chg_active` is sampled high on N consecutive clock edges (N at least 1) and then low, and N is not greater than `tmo_limit`, the next edge loads `elapsed` with N. `tmo_flag` is left unchanged.
- R3: If charging is still active on the edge where the timer equals `tmo_limit` (that is, N greater than `tmo_limit`), that edge loads `elapsed` with `tmo_limit` and sets `tmo_flag`.
- R4: With `tmo_limit` equal to 0, the first sampled edge of charging sets `tmo_flag` and loads `elapsed` with 0.
- R5: `elapsed` holds its value during a later charging episode until that episode stops. After a timeout the timer stays stopped, so the later fall of `chg_active` leaves `elapsed` unchanged.
- R6: Every rising edge of `chg_active` restarts the timer from 0, whatever the previous episode left behind.
- R7: `tmo_flag` is sticky. A high `flag_clr` on an edge clears it, except that a timeout on the same edge wins and leaves the flag at 1.
- R8: `tmo_irq` is high exactly when `tmo_flag` and `tmo_irq_en` are both 1.
- R9: With `tmo_limit` at its maximum of 8191, the timer never wraps. 8191 charging edges give `elapsed` 8191 and no flag. 8192 or more give `elapsed` 8191 and the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chg_active | input | 1 | High while the charge pump is charging |
| tmo_limit | input | 13 | Timeout value of the timer |
| tmo_irq_en | input | 1 | Timeout interrupt enable |
| flag_clr | input | 1 | Write-1-to-clear pulse for the timeout flag |
| elapsed | output | 13 | Captured timer value, read-only |
| tmo_flag | output | 1 | Sticky timeout flag |
| tmo_irq | output | 1 | Timeout interrupt request |

## Verification
The bench sweeps every pairing of limits 0 to 12 with charging lengths 1 to 14. This catches an off-by-one at the boundary where length equals limit. A design that compared one cycle late would report limit+1 and flag a length equal to the limit. A design that did not restart from zero would accumulate counts across episodes.

Separate cases target the behaviour after a timeout and the clear-versus-set collision on one edge. After a timeout, a wrong design would overwrite `elapsed` when charging falls. On the collision edge, a wrong design would lose the flag. A maximum-limit run exposes a timer that wraps past 8191 instead of stopping.

// File: rtl/chgpump_timer.sv
module chgpump_timer #(
  parameter int CNT_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chg_active,
  input  logic [CNT_W-1:0] tmo_limit,
  input  logic             tmo_irq_en,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] elapsed,
  output logic             tmo_flag,
  output logic             tmo_irq
);

  logic             chg_q;
  logic             run;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cur;
  logic             rise, active, hit, stop;

  assign rise   = chg_active & ~chg_q;
  assign active = rise | (run & chg_active);
  assign cur    = rise ? '0 : cnt;
  assign hit    = active & (cur == tmo_limit);
  assign stop   = run & ~chg_active;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chg_q    <= 1'b0;
      run      <= 1'b0;
      cnt      <= '0;
      elapsed  <= '0;
      tmo_flag <= 1'b0;
    end else begin
      chg_q <= chg_active;
      if (hit) begin
        elapsed <= cur;
        run     <= 1'b0;
      end else if (active) begin
        cnt <= cur + CNT_W'(1);
        run <= 1'b1;
      end else if (stop) begin
        elapsed <= cnt;
        run     <= 1'b0;
      end
      if (hit)
        tmo_flag <= 1'b1;
      else if (flag_clr)
        tmo_flag <= 1'b0;
    end
  end

  assign tmo_irq = tmo_flag & tmo_irq_en;

  // R3
  timeout_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && chg_active && cnt == tmo_limit) |=> (tmo_flag && elapsed == $past(tmo_limit)));

  // R2
  stop_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !chg_active && !flag_clr) |=> (elapsed == $past(cnt) && $stable(tmo_flag)));

  // R5
  elapsed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !(chg_active && !chg_q)) |=> $stable(elapsed));

  // R6
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chg_active && !chg_q) |=> (!run || cnt == CNT_W'(1)));

  // R7
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_flag && !flag_clr) |=> tmo_flag);

  // R8
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_irq |-> (tmo_flag && tmo_irq_en));

endmodule

// File: tb/chgpump_timer_tb_top.sv
`timescale 1ns/1ps
module chgpump_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        chg_active = 1'b0;
  logic [12:0] tmo_limit = '0;
  logic        tmo_irq_en = 1'b0;
  logic        flag_clr = 1'b0;
  logic [12:0] elapsed;
  logic        tmo_flag;
  logic        tmo_irq;
  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  chgpump_timer #(.CNT_W(13)) dut_i (
    .clk(clk), .rst_n(rst_n), .chg_active(chg_active), .tmo_limit(tmo_limit),
    .tmo_irq_en(tmo_irq_en), .flag_clr(flag_clr), .elapsed(elapsed),
    .tmo_flag(tmo_flag), .tmo_irq(tmo_irq));

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_flag();
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
  endtask

  task automatic episode(int n, int lim);
    tmo_limit = 13'(lim);
    chg_active = 1'b1;
    repeat (n) @(negedge clk);
    chg_active = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 elapsed", elapsed, 0);
    check("R1 flag", tmo_flag, 0);
    check("R1 irq", tmo_irq, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R3 R4 R6: sweep of limit and length
    for (int lim = 0; lim <= 12; lim++) begin
      for (int n = 1; n <= 14; n++) begin
        clear_flag();
        episode(n, lim);
        check(n > lim ? (lim == 0 ? "R4 elapsed" : "R3 elapsed") : "R2 elapsed",
              elapsed, n > lim ? lim : n);
        check(n > lim ? "R3 flag" : "R2 flag", tmo_flag, n > lim ? 1 : 0);
      end
    end

    // R5: held during a later episode, untouched by fall after timeout
    clear_flag();
    episode(5, 100);
    tmo_limit = 13'd100;
    chg_active = 1'b1;
    repeat (3) @(negedge clk);
    check("R5 hold mid-episode", elapsed, 5);
    chg_active = 1'b0;
    repeat (2) @(negedge clk);
    check("R5 new capture", elapsed, 3);
    clear_flag();
    tmo_limit = 13'd4;
    chg_active = 1'b1;
    repeat (6) @(negedge clk);
    check("R5 after timeout", elapsed, 4);
    clear_flag();
    repeat (3) @(negedge clk);
    chg_active = 1'b0;
    repeat (3) @(negedge clk);
    check("R5 fall after timeout", elapsed, 4);
    check("R5 no new flag", tmo_flag, 0);

    // R7: sticky and set-over-clear
    episode(3, 1);
    repeat (5) @(negedge clk);
    check("R7 sticky", tmo_flag, 1);
    clear_flag();
    check("R7 cleared", tmo_flag, 0);
    tmo_limit = 13'd3;
    chg_active = 1'b1;
    repeat (3) @(negedge clk);
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    check("R7 set wins", tmo_flag, 1);
    chg_active = 1'b0;
    @(negedge clk);

    // R8: interrupt gating
    tmo_irq_en = 1'b0;
    @(negedge clk);
    check("R8 flag only", tmo_irq, 0);
    tmo_irq_en = 1'b1;
    @(negedge clk);
    check("R8 both", tmo_irq, 1);
    clear_flag();
    check("R8 enable only", tmo_irq, 0);
    tmo_irq_en = 1'b0;

    // R9: maximum limit
    episode(8191, 8191);
    check("R9 no timeout elapsed", elapsed, 8191);
    check("R9 no timeout flag", tmo_flag, 0);
    episode(8195, 8191);
    check("R9 timeout elapsed", elapsed, 8191);
    check("R9 timeout flag", tmo_flag, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule